// File: doc/BRIEF.md
# Non-Pipelined Divider Busy Interlock

This block keeps the timing picture of one integer divide unit that cannot accept a new operation while it is working, together with the hi/lo result registers that the divide writes at its end. It carries no arithmetic. It sees a divide-issue request with a width flag, plus requests from other instructions to read or write hi/lo. From these it produces a busy indication for the divider, a stall for a new divide that would collide with the one in progress, and a stall for hi/lo accesses while a divide result is still pending.

Cycles are numbered per divide. The cycle in which a request is granted is cycle 1. The divider itself is not claimed until cycle 5, and it is held for 32 cycles (32-bit) or 64 cycles (64-bit). The latency cycle is therefore 36 or 68, and hi/lo are written four cycles later, at cycle 40 or 72. A new divide is accepted as soon as its own reservation would begin right after the current one ends. Two divides can therefore share their quiet lead-in and trailing cycles while their reservations never overlap.

Top module: `divider_interlock`

## Requirements
- R1: A synchronous reset clears all tracking. In the idle cycle after reset `div_busy`, `div_stall` and `hilo_stall` are 0 even with every request high, and a reset mid-divide drops all of them at once.
- R2: A granted divide is cycle 1 (the cycle with `div_req`=1 and `div_stall`=0). With no other divide in flight, `div_busy` stays 0 in cycles 2, 3 and 4 and is 1 from cycle 5.
- R3: For a 32-bit divide (`div_wide`=0, sampled in cycle 1), `div_busy` is 1 in cycles 5 to 36 and 0 in cycle 37.
- R4: For a 64-bit divide (`div_wide`=1), `div_busy` is 1 in cycles 5 to 68 and 0 in cycle 69.
- R5: A divide request is stalled while the divide in flight is in cycle H or earlier (H = 32 or 64 by that divide's width), and it is granted from cycle H+1 on.
- R6: A divide granted in cycle H+1 of the previous one makes `div_busy` run without a gap from the first divide's reservation into the second's.
- R7: While a divide is in flight, from its cycle 2 through its hi/lo write cycle (40 or 72), a hi/lo read or write request gets `hilo_stall`=1. From the cycle after the write, the stall is 0.
- R8: `div_stall` is 1 only in a cycle with `div_req`=1, and `hilo_stall` is 1 only in a cycle with a hi/lo request.
- R9: When two divides overlap, `hilo_stall` holds until the later divide's write cycle.
- R10: A stalled divide request leaves no trace. The running divide's busy and hi/lo windows end at their original cycles, and a later request is granted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| div_req | input | 1 | Request to issue a divide this cycle |
| div_wide | input | 1 | Width of the requested divide: 1 = 64-bit, 0 = 32-bit |
| hilo_rd_req | input | 1 | Another instruction wants to read hi/lo this cycle |
| hilo_wr_req | input | 1 | Another instruction wants to write hi/lo this cycle |
| div_busy | output | 1 | Divider reservation is held this cycle |
| div_stall | output | 1 | The divide request this cycle must not issue |
| hilo_stall | output | 1 | The hi/lo access this cycle must not issue |

## Verification
Every cycle the assertions check these rules: a stall appears only with its own request, grants are spaced by at least the hold length of the previous divide, a lone divide is quiet in the cycle after issue, a hi/lo write right after a grant is always held back, and a grant never finds all trackers full. The exact cycle numbers can only be shown by the bench's scenarios. Those include the first and last busy cycles for each width, the first cycle a second divide is accepted, the seamless hand-over of the reservation, the extended hi/lo window of two overlapping divides, and the absence of any effect from a refused request.

// File: rtl/divlock_pkg.sv
package divlock_pkg;

  // Cycle number a tracker holds in the cycle right after the grant edge.
  localparam int unsigned FIRST_TRACKED = 2;

  function automatic int unsigned hold_of(input logic wide,
                                          input int unsigned narrow_hold,
                                          input int unsigned wide_hold);
    return wide ? wide_hold : narrow_hold;
  endfunction

  // First cycle of the divider reservation.
  function automatic int unsigned busy_first(input int unsigned lead);
    return lead + 1;
  endfunction

  // Latency cycle: last cycle of the divider reservation.
  function automatic int unsigned busy_last(input int unsigned hold,
                                            input int unsigned lead);
    return hold + lead;
  endfunction

  // Cycle in which the divide writes hi/lo.
  function automatic int unsigned wb_cycle(input int unsigned hold,
                                           input int unsigned lead,
                                           input int unsigned gap);
    return hold + lead + gap;
  endfunction

  // First cycle of a running divide in which a successor may be granted.
  function automatic int unsigned release_cycle(input int unsigned hold);
    return hold + 1;
  endfunction

endpackage

// File: rtl/divlock_slot.sv
module divlock_slot
  import divlock_pkg::*;
#(
  parameter int unsigned HOLD_NARROW = 32,
  parameter int unsigned HOLD_WIDE   = 64,
  parameter int unsigned LEAD        = 4,
  parameter int unsigned WB_GAP      = 4,
  parameter int unsigned AW          = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_wide,
  output logic active,
  output logic busy,
  output logic holding,
  output logic wb_now
);

  logic [AW-1:0] age_q;
  logic          wide_q;
  logic          act_q;
  int unsigned   hold_c;

  always_comb begin
    hold_c  = hold_of(wide_q, HOLD_NARROW, HOLD_WIDE);
    active  = act_q;
    busy    = act_q
              && (age_q >= AW'(busy_first(LEAD)))
              && (age_q <= AW'(busy_last(hold_c, LEAD)));
    holding = act_q && (age_q < AW'(release_cycle(hold_c)));
    wb_now  = act_q && (age_q == AW'(wb_cycle(hold_c, LEAD, WB_GAP)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      age_q  <= '0;
      wide_q <= 1'b0;
    end else if (load) begin
      act_q  <= 1'b1;
      age_q  <= AW'(FIRST_TRACKED);
      wide_q <= load_wide;
    end else if (act_q) begin
      if (wb_now) begin
        act_q <= 1'b0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/divlock_alloc.sv
module divlock_alloc #(
  parameter int unsigned NSLOT = 2
) (
  input  logic             div_req,
  input  logic [NSLOT-1:0] slot_active,
  input  logic [NSLOT-1:0] slot_holding,
  output logic             grant,
  output logic             stall,
  output logic [NSLOT-1:0] load_vec
);

  logic blocked;
  logic placed;

  always_comb begin
    blocked  = |slot_holding;
    grant    = div_req && !blocked;
    stall    = div_req && blocked;
    load_vec = '0;
    placed   = 1'b0;
    for (int i = 0; i < int'(NSLOT); i++) begin
      if (grant && !placed && !slot_active[i]) begin
        load_vec[i] = 1'b1;
        placed      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/divider_interlock.sv
module divider_interlock #(
  parameter int unsigned HOLD_NARROW = 32,
  parameter int unsigned HOLD_WIDE   = 64,
  parameter int unsigned LEAD        = 4,
  parameter int unsigned WB_GAP      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic div_req,
  input  logic div_wide,
  input  logic hilo_rd_req,
  input  logic hilo_wr_req,
  output logic div_busy,
  output logic div_stall,
  output logic hilo_stall
);

  localparam int unsigned LIFE  = HOLD_WIDE + LEAD + WB_GAP;
  localparam int unsigned AW    = $clog2(LIFE + 2);
  localparam int unsigned NSLOT = 1 + (LEAD + WB_GAP + HOLD_NARROW - 1) / HOLD_NARROW;

  logic [NSLOT-1:0] slot_active;
  logic [NSLOT-1:0] slot_busy;
  logic [NSLOT-1:0] slot_holding;
  logic [NSLOT-1:0] slot_wb;
  logic [NSLOT-1:0] slot_load;
  logic             div_grant;
  logic             in_flight;
  logic             hilo_wb;

  divlock_alloc #(.NSLOT(NSLOT)) alloc_i (
    .div_req      (div_req),
    .slot_active  (slot_active),
    .slot_holding (slot_holding),
    .grant        (div_grant),
    .stall        (div_stall),
    .load_vec     (slot_load)
  );

  for (genvar g = 0; g < int'(NSLOT); g++) begin : g_slot
    divlock_slot #(
      .HOLD_NARROW (HOLD_NARROW),
      .HOLD_WIDE   (HOLD_WIDE),
      .LEAD        (LEAD),
      .WB_GAP      (WB_GAP),
      .AW          (AW)
    ) slot_i (
      .clk       (clk),
      .rst       (rst),
      .load      (slot_load[g]),
      .load_wide (div_wide),
      .active    (slot_active[g]),
      .busy      (slot_busy[g]),
      .holding   (slot_holding[g]),
      .wb_now    (slot_wb[g])
    );
  end

  always_comb begin
    in_flight  = |slot_active;
    hilo_wb    = |slot_wb;
    div_busy   = |slot_busy;
    hilo_stall = (hilo_rd_req || hilo_wr_req) && in_flight;
  end

endmodule

// File: rtl/divider_interlock_chk.sv
module divider_interlock_chk
  import divlock_pkg::*;
#(
  parameter int unsigned HOLD_NARROW = 32,
  parameter int unsigned HOLD_WIDE   = 64,
  parameter int unsigned NSLOT       = 2,
  parameter int unsigned AW          = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             div_req,
  input logic             div_wide,
  input logic             hilo_rd_req,
  input logic             hilo_wr_req,
  input logic             div_busy,
  input logic             div_stall,
  input logic             hilo_stall,
  input logic             div_grant,
  input logic [NSLOT-1:0] slot_active,
  input logic             hilo_wb
);

  localparam int unsigned CW = AW + 1;

  logic [CW-1:0] since_q;
  logic          seen_q;
  int unsigned   last_hold_q;
  int unsigned   wb_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q     <= '0;
      seen_q      <= 1'b0;
      last_hold_q <= 0;
      wb_seen_q   <= 0;
    end else begin
      if (hilo_wb) wb_seen_q <= wb_seen_q + 1;
      if (div_grant) begin
        since_q     <= CW'(FIRST_TRACKED);
        seen_q      <= 1'b1;
        last_hold_q <= hold_of(div_wide, HOLD_NARROW, HOLD_WIDE);
      end else if (seen_q && since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  a_r8_div_stall_needs_req: assert property (@(posedge clk) disable iff (rst)
    div_stall |-> div_req);

  a_r8_hilo_stall_needs_req: assert property (@(posedge clk) disable iff (rst)
    hilo_stall |-> (hilo_rd_req || hilo_wr_req));

  a_r2_quiet_after_lone_issue: assert property (@(posedge clk) disable iff (rst)
    (div_grant && slot_active == '0) |=> !div_busy);

  a_r5_release_spacing: assert property (@(posedge clk) disable iff (rst)
    (div_grant && seen_q) |-> (32'(since_q) >= release_cycle(last_hold_q)));

  a_r7_write_blocked_after_grant: assert property (@(posedge clk) disable iff (rst)
    div_grant |=> (!hilo_wr_req || hilo_stall));

  a_r9_tracker_room: assert property (@(posedge clk) disable iff (rst)
    div_grant |-> (slot_active != '1));

endmodule

bind divider_interlock divider_interlock_chk #(
  .HOLD_NARROW (HOLD_NARROW),
  .HOLD_WIDE   (HOLD_WIDE),
  .NSLOT       (NSLOT),
  .AW          (AW)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .div_req     (div_req),
  .div_wide    (div_wide),
  .hilo_rd_req (hilo_rd_req),
  .hilo_wr_req (hilo_wr_req),
  .div_busy    (div_busy),
  .div_stall   (div_stall),
  .hilo_stall  (hilo_stall),
  .div_grant   (div_grant),
  .slot_active (slot_active),
  .hilo_wb     (hilo_wb)
);

// File: tb/divider_interlock_tb.sv
module divider_interlock_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic div_req = 1'b0;
  logic div_wide = 1'b0;
  logic hilo_rd_req = 1'b0;
  logic hilo_wr_req = 1'b0;
  logic div_busy;
  logic div_stall;
  logic hilo_stall;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  divider_interlock dut_i (
    .clk         (clk),
    .rst         (rst),
    .div_req     (div_req),
    .div_wide    (div_wide),
    .hilo_rd_req (hilo_rd_req),
    .hilo_wr_req (hilo_wr_req),
    .div_busy    (div_busy),
    .div_stall   (div_stall),
    .hilo_stall  (hilo_stall)
  );

  // {wide, cycle number of the probe}
  localparam int NV = 18;
  localparam logic [7:0] VEC [NV] = '{
    {1'b0, 7'd2},  {1'b0, 7'd4},  {1'b0, 7'd5},  {1'b0, 7'd20},
    {1'b0, 7'd32}, {1'b0, 7'd33}, {1'b0, 7'd36}, {1'b0, 7'd37},
    {1'b0, 7'd40}, {1'b0, 7'd41},
    {1'b1, 7'd4},  {1'b1, 7'd5},  {1'b1, 7'd64}, {1'b1, 7'd65},
    {1'b1, 7'd68}, {1'b1, 7'd69}, {1'b1, 7'd72}, {1'b1, 7'd73}
  };

  function automatic int hold_f(input bit w);
    return w ? 64 : 32;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b",
               tag, what, cur, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    div_req = 1'b0;
    hilo_rd_req = 1'b0;
    hilo_wr_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur = 0;
  endtask

  task automatic issue(input bit w);
    div_req = 1'b1;
    div_wide = w;
    cur = 1;
    #1;
    check("R2", "issue div_stall", div_stall, 1'b0);
    @(negedge clk);
    div_req = 1'b0;
    cur = 2;
  endtask

  task automatic go(input int n);
    while (cur < n) begin
      @(negedge clk);
      cur++;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    // Table walk: busy, hi/lo and issue windows per width and cycle.
    for (int v = 0; v < NV; v++) begin
      bit w;
      int n;
      int h;
      string btag;
      w = VEC[v][7];
      n = int'(VEC[v][6:0]);
      h = hold_f(w);
      btag = (n <= 4) ? "R2" : (w ? "R4" : "R3");
      do_reset();
      issue(w);
      go(n);
      hilo_rd_req = 1'b1;
      div_req = 1'b1;
      div_wide = 1'b0;
      #1;
      check(btag, "div_busy", div_busy, logic'(n >= 5 && n <= h + 4));
      check("R7", "hilo_stall", hilo_stall, logic'(n >= 2 && n <= h + 8));
      check("R5", "div_stall", div_stall, logic'(n <= h));
      div_req = 1'b0;
      hilo_rd_req = 1'b0;
    end

    // R1: idle after reset with all requests high.
    do_reset();
    hilo_rd_req = 1'b1;
    hilo_wr_req = 1'b1;
    div_req = 1'b1;
    #1;
    check("R1", "div_busy after reset", div_busy, 1'b0);
    check("R1", "div_stall after reset", div_stall, 1'b0);
    check("R1", "hilo_stall after reset", hilo_stall, 1'b0);
    div_req = 1'b0;
    hilo_rd_req = 1'b0;
    hilo_wr_req = 1'b0;

    // R1: reset in the middle of a divide; R8: no stall without requests.
    do_reset();
    issue(1'b0);
    go(10);
    #1;
    check("R8", "div_busy mid divide", div_busy, 1'b1);
    check("R8", "div_stall without request", div_stall, 1'b0);
    check("R8", "hilo_stall without request", hilo_stall, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hilo_rd_req = 1'b1;
    #1;
    check("R1", "div_busy after mid reset", div_busy, 1'b0);
    check("R1", "hilo_stall after mid reset", hilo_stall, 1'b0);
    hilo_rd_req = 1'b0;

    // R6 and R9: successor granted at cycle 33 of a 32-bit divide.
    do_reset();
    issue(1'b0);
    go(33);
    div_req = 1'b1;
    div_wide = 1'b0;
    #1;
    check("R6", "successor div_stall", div_stall, 1'b0);
    @(negedge clk);
    cur++;
    #1;
    check("R5", "third request div_stall", div_stall, 1'b1);
    div_req = 1'b0;
    go(36);
    #1;
    check("R6", "div_busy old last cycle", div_busy, 1'b1);
    go(37);
    #1;
    check("R6", "div_busy hand-over", div_busy, 1'b1);
    go(41);
    hilo_wr_req = 1'b1;
    #1;
    check("R9", "hilo_stall after first write", hilo_stall, 1'b1);
    hilo_wr_req = 1'b0;
    go(68);
    #1;
    check("R6", "div_busy successor cycle 36", div_busy, 1'b1);
    go(69);
    #1;
    check("R6", "div_busy successor done", div_busy, 1'b0);
    go(72);
    hilo_wr_req = 1'b1;
    #1;
    check("R9", "hilo_stall successor write cycle", hilo_stall, 1'b1);
    go(73);
    #1;
    check("R9", "hilo_stall cleared", hilo_stall, 1'b0);
    hilo_wr_req = 1'b0;

    // R10: a refused 64-bit request leaves no trace.
    do_reset();
    issue(1'b0);
    go(10);
    div_req = 1'b1;
    div_wide = 1'b1;
    #1;
    check("R10", "refused div_stall", div_stall, 1'b1);
    @(negedge clk);
    cur++;
    div_req = 1'b0;
    go(37);
    #1;
    check("R10", "div_busy ends on time", div_busy, 1'b0);
    go(41);
    hilo_rd_req = 1'b1;
    #1;
    check("R10", "hilo_stall ends on time", hilo_stall, 1'b0);
    hilo_rd_req = 1'b0;
    go(50);
    div_req = 1'b1;
    div_wide = 1'b0;
    #1;
    check("R10", "later request granted", div_stall, 1'b0);
    @(negedge clk);
    div_req = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule